// File: doc/BRIEF.md
# Stereo Sample Serializer for a Clock-Master Codec

This block takes packed stereo words from an upstream sample FIFO and shifts them, MSB first, onto the serial data pin of a codec DAC. The codec owns the timing. It drives the bit clock and the word-select (frame) clock. The block does not run on either of those clocks. It oversamples both in a much faster system clock, turns their transitions into single-cycle pulses, and updates the data pin after each detected bit-clock fall. The codec then samples the pin on the following bit-clock rise.

Each 32-bit word carries two 16-bit samples. The low half is the first (left) channel and the high half is the second (right) channel. The block asks the FIFO for one word per frame and takes the returned word one cycle after the strobe. A 2-bit format input selects one of four framings while the block runs: left-justified, I2S-style delayed, right-justified or DSP. A new format is adopted only when the next frame begins. If the FIFO is empty when a word is due, the block sends silence and records the event.

Top module: `dac_serializer`

## Requirements
- R1: While reset is asserted and after it is released, with no frame clock edge seen, `sdata`, `fifoRd` and `underrun` are all 0.
- R2: Format 0 (left-justified): bit 15 of the channel sample is on `sdata` during bit-clock period 0. Period 0 is the one that begins with the frame clock edge. The remaining bits follow one per period, MSB first, down to bit 0 in period 15.
- R3: In formats 0, 1 and 2, the half-frame with `lrckIn` high carries word bits 15..0 and the half-frame with `lrckIn` low carries word bits 31..16.
- R4: Format 1 (delayed): the MSB is in period 1 and the LSB is in period 16.
- R5: Format 2 (right-justified): the LSB is in the last bit-clock period before the next frame clock edge. The start offset is (length of the previous half-frame in periods − 16). The offset is 0 if the previous half-frame was shorter than 16 periods.
- R6: `fifoRd` pulses high for exactly one cycle per `lrckIn` rising edge and never on a falling edge. The word present on `fifoWord` in the cycle after the pulse is the one serialized.
- R7: Outside its active bit slots, `sdata` is 0.
- R8: Format 3 (DSP): a rising `lrckIn` starts a frame, and a falling `lrckIn` neither restarts the frame nor reads. 32 bits follow back to back from period 0: word bits 15..0, then word bits 31..16, each MSB first.
- R9: If `fifoEmpty` is high in the `fifoRd` cycle, an all-zero word is serialized and `underrun` goes high two cycles later. `underrun` then stays high until reset.
- R10: A change on `fmtSel` is taken into use at the next `lrckIn` rising edge. The half-frame in progress and the following low half keep the format latched at the last rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bclkIn | input | 1 | Bit clock from the codec, asynchronous |
| lrckIn | input | 1 | Frame (word-select) clock from the codec, asynchronous |
| fmtSel | input | 2 | Framing: 0 left-justified, 1 delayed, 2 right-justified, 3 DSP |
| fifoWord | input | 32 | Word returned by the FIFO, bits 15..0 left, 31..16 right |
| fifoEmpty | input | 1 | FIFO has no word available |
| fifoRd | output | 1 | One-cycle read strobe to the FIFO |
| sdata | output | 1 | Serial data to the codec DAC |
| underrun | output | 1 | Sticky flag: a zero word was substituted |

## Verification
The codec moves the frame clock on a bit-clock fall, so a frame clock edge pulse and a bit-clock fall pulse arrive in the same system cycle. The slot counter must then restart at period 0 rather than advance. The bench always toggles both clocks at the same instant. It judges the outcome by the period in which the MSB appears in each format, which is off by one if the increment wins. A format change that lands during a frame is also provoked between the two halves, and the bench checks that the low half keeps the old framing.

// File: rtl/dacser_pkg.sv
package dacser_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SAMPLE_W = 16;
  localparam int WORD_W   = 2 * SAMPLE_W;
  localparam int IDX_W    = $clog2(WORD_W);

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_DELAY = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_DSP   = 2'd3
  } fmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             readNow;
    logic             loadWord;
    logic             bitValid;
    logic [IDX_W-1:0] bitIdx;
  } slot_ctl_t;
endpackage

// File: rtl/dacser_edge.sv
module dacser_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic rise,
  output logic fall
);
  timeunit 1ns;
  timeprecision 100ps;

  // STAGES synchronizer flops plus one history flop for edge compare
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], sigIn};
  end

  assign rise =  chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/dacser_ctrl.sv
module dacser_ctrl
  import dacser_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lrRise,
  input  logic      lrFall,
  input  logic      bFall,
  input  logic [1:0] fmtIn,
  output slot_ctl_t ctl
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] SW      = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] WW      = CNT_W'(WORD_W);

  fmt_e             fmtAct;
  logic [CNT_W-1:0] slot;
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W-1:0] slotInc;
  logic             chanHi;
  logic             running;
  logic             loadPend;
  logic             dspMode;

  assign dspMode = (fmtAct == FMT_DSP);
  assign slotInc = (slot == CNT_MAX) ? slot : slot + 1'b1;

  // frame clock edge wins over the coincident bit clock fall: restart at slot 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtAct   <= FMT_LEFT;
      slot     <= '0;
      halfLen  <= '0;
      chanHi   <= 1'b0;
      running  <= 1'b0;
      loadPend <= 1'b0;
    end else begin
      loadPend <= lrRise;
      if (lrRise) begin
        fmtAct  <= fmt_e'(fmtIn);
        halfLen <= slotInc;
        slot    <= '0;
        chanHi  <= 1'b0;
        running <= 1'b1;
      end else if (lrFall && !dspMode) begin
        halfLen <= slotInc;
        slot    <= '0;
        chanHi  <= 1'b1;
      end else if (bFall) begin
        slot <= slotInc;
      end
    end
  end

  logic [CNT_W-1:0] lead;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] pos;
  int               posI;
  int               idxI;

  always_comb begin
    unique case (fmtAct)
      FMT_DELAY: lead = CNT_W'(1);
      FMT_RIGHT: lead = (halfLen >= SW) ? halfLen - SW : '0;
      default:   lead = '0;
    endcase
    span = dspMode ? WW : SW;
    pos  = slot - lead;
    posI = int'(pos);
    if (dspMode && posI >= SAMPLE_W) idxI = WORD_W + SAMPLE_W - 1 - posI;
    else if (dspMode)                idxI = SAMPLE_W - 1 - posI;
    else                             idxI = (chanHi ? WORD_W - 1 : SAMPLE_W - 1) - posI;

    ctl.readNow  = lrRise;
    ctl.loadWord = loadPend;
    ctl.bitValid = running && (slot >= lead) && (pos < span);
    ctl.bitIdx   = ctl.bitValid ? IDX_W'(idxI) : '0;
  end
endmodule

// File: rtl/dacser_dp.sv
module dacser_dp
  import dacser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  slot_ctl_t         ctl,
  input  logic [WORD_W-1:0] fifoWord,
  input  logic              fifoEmpty,
  output logic              sdata,
  output logic              underrun
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [WORD_W-1:0] wordReg;
  logic              emptyQ;
  logic              underrunQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg   <= '0;
      emptyQ    <= 1'b0;
      underrunQ <= 1'b0;
    end else begin
      if (ctl.readNow) emptyQ <= fifoEmpty;
      if (ctl.loadWord) begin
        wordReg <= emptyQ ? '0 : fifoWord;
        if (emptyQ) underrunQ <= 1'b1;
      end
    end
  end

  assign sdata    = ctl.bitValid & wordReg[ctl.bitIdx];
  assign underrun = underrunQ;
endmodule

// File: rtl/dac_serializer.sv
module dac_serializer
  import dacser_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bclkIn,
  input  logic              lrckIn,
  input  logic [1:0]        fmtSel,
  input  logic [WORD_W-1:0] fifoWord,
  input  logic              fifoEmpty,
  output logic              fifoRd,
  output logic              sdata,
  output logic              underrun
);
  timeunit 1ns;
  timeprecision 100ps;

  logic      bRise;
  logic      bFall;
  logic      lrRise;
  logic      lrFall;
  slot_ctl_t ctl;

  dacser_edge #(.STAGES(SYNC_STAGES)) u_bEdge (
    .clk(clk), .rstN(rstN), .sigIn(bclkIn), .rise(bRise), .fall(bFall)
  );

  dacser_edge #(.STAGES(SYNC_STAGES)) u_lrEdge (
    .clk(clk), .rstN(rstN), .sigIn(lrckIn), .rise(lrRise), .fall(lrFall)
  );

  dacser_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lrRise(lrRise), .lrFall(lrFall),
    .bFall(bFall), .fmtIn(fmtSel), .ctl(ctl)
  );

  dacser_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fifoWord(fifoWord),
    .fifoEmpty(fifoEmpty), .sdata(sdata), .underrun(underrun)
  );

  assign fifoRd = ctl.readNow;

  // bit clock rise is not needed: data moves on falls, codec samples on rises
  logic unusedRise;
  assign unusedRise = bRise;
endmodule

// File: rtl/dacser_checker.sv
module dacser_checker (
  input logic clk,
  input logic rstN,
  input logic fifoRd,
  input logic fifoEmpty,
  input logic underrun
);
  timeunit 1ns;
  timeprecision 100ps;

  // R6: read strobe lasts one cycle
  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> !fifoRd);

  // R9: flag never clears
  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);

  // R9: empty at a read raises the flag two cycles on
  a_r9_underrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRd && fifoEmpty) |=> ##1 underrun);

  // R9: flag rises only after an empty read
  a_r9_underrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $past(fifoRd && fifoEmpty, 2));
endmodule

bind dac_serializer dacser_checker u_chk (
  .clk(clk), .rstN(rstN), .fifoRd(fifoRd), .fifoEmpty(fifoEmpty), .underrun(underrun)
);

// File: tb/dac_serializer_bench.sv
module dac_serializer_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int BLO   = 8;
  localparam int BHI   = 8;
  localparam int LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bclk = 1'b0;
  logic        lrck = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [31:0] fifoWord = '0;
  logic [31:0] nextWord = '0;
  logic        fifoEmpty = 1'b0;
  logic        fifoRd;
  logic        sdata;
  logic        underrun;

  int checks = 0;
  int errors = 0;
  int rdCount = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dac_serializer u_dac_serializer (
    .clk(clk), .rstN(rstN), .bclkIn(bclk), .lrckIn(lrck), .fmtSel(fmt),
    .fifoWord(fifoWord), .fifoEmpty(fifoEmpty), .fifoRd(fifoRd),
    .sdata(sdata), .underrun(underrun)
  );

  // FIFO model: word appears the cycle after the strobe
  always @(negedge clk) begin
    if (rstN && fifoRd) begin
      rdCount = rdCount + 1;
      if (!fifoEmpty) fifoWord = nextWord;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expBits(input int m, input logic [15:0] s, input int nB, input int prevLen);
    logic [63:0] e;
    int off;
    e = '0;
    off = (m == 1) ? 1 : (m == 2) ? ((prevLen >= 16) ? prevLen - 16 : 0) : 0;
    for (int p = 0; p < nB; p++) begin
      if (p - off >= 0 && p - off < 16) e[p] = s[15 - (p - off)];
    end
    return e;
  endfunction

  task automatic playHalf(input logic lvl, input int nB, output logic [63:0] bits);
    bits = '0;
    for (int j = 0; j < nB; j++) begin
      @(negedge clk);
      bclk = 1'b0;
      if (j == 0) lrck = lvl;
      repeat (BLO) @(negedge clk);
      bclk = 1'b1;
      repeat (BHI / 2) @(negedge clk);
      bits[j] = sdata;
      repeat (BHI / 2 - 1) @(negedge clk);
    end
  endtask

  task automatic playFrame(input int m, input logic [31:0] w, input int nB,
                           output logic [63:0] lb, output logic [63:0] rb);
    fmt = 2'(m);
    nextWord = w;
    playHalf(1'b1, nB, lb);
    playHalf(1'b0, nB, rb);
  endtask

  task automatic testReset();
    check(sdata == 1'b0 && fifoRd == 1'b0 && underrun == 1'b0, "R1 in reset",
          {61'b0, sdata, fifoRd, underrun}, 64'h0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(sdata == 1'b0 && fifoRd == 1'b0 && underrun == 1'b0, "R1 after release",
          {61'b0, sdata, fifoRd, underrun}, 64'h0);
  endtask

  task automatic testLeft();
    logic [63:0] lb, rb;
    logic [31:0] w;
    int r0;
    w = 32'h3C96_A51E;
    r0 = rdCount;
    playFrame(0, w, 32, lb, rb);
    check(lb == expBits(0, w[15:0], 32, 32), "R2 R3 left-justified high half", lb, expBits(0, w[15:0], 32, 32));
    check(rb == expBits(0, w[31:16], 32, 32), "R3 left-justified low half", rb, expBits(0, w[31:16], 32, 32));
    check((lb >> 16) == 64'h0, "R7 idle slots zero", lb >> 16, 64'h0);
    check(rdCount - r0 == 1, "R6 one read per frame", 64'(rdCount - r0), 64'd1);
  endtask

  task automatic testDelay();
    logic [63:0] lb, rb;
    logic [31:0] w;
    w = 32'h8001_7FFE;
    playFrame(1, w, 32, lb, rb);
    check(lb == expBits(1, w[15:0], 32, 32), "R4 delayed high half", lb, expBits(1, w[15:0], 32, 32));
    check(rb == expBits(1, w[31:16], 32, 32), "R4 delayed low half", rb, expBits(1, w[31:16], 32, 32));
  endtask

  task automatic testRight();
    logic [63:0] lb, rb;
    logic [31:0] w;
    w = 32'hC3A5_96F1;
    playFrame(2, 32'h1234_5678, 24, lb, rb);
    playFrame(2, w, 24, lb, rb);
    check(lb == expBits(2, w[15:0], 24, 24), "R5 right-justified high half", lb, expBits(2, w[15:0], 24, 24));
    check(rb == expBits(2, w[31:16], 24, 24), "R5 right-justified low half", rb, expBits(2, w[31:16], 24, 24));
    check(lb[23] == w[0], "R5 LSB in last period", {63'b0, lb[23]}, {63'b0, w[0]});
  endtask

  task automatic testDsp();
    logic [63:0] a, b, c, e;
    logic [31:0] w;
    int r0;
    w = 32'hE71B_4D2C;
    fmt = 2'd3;
    nextWord = w;
    r0 = rdCount;
    playHalf(1'b1, 1, a);
    playHalf(1'b0, 39, b);
    c = {b[62:0], a[0]};
    e = '0;
    for (int p = 0; p < 16; p++) e[p] = w[15 - p];
    for (int p = 16; p < 32; p++) e[p] = w[47 - p];
    check(c == e, "R8 DSP 32 contiguous bits", c, e);
    check(rdCount - r0 == 1, "R8 R6 no read on fall", 64'(rdCount - r0), 64'd1);
  endtask

  task automatic testModeChange();
    logic [63:0] lb, rb;
    logic [31:0] w;
    w = 32'h5AC3_0FF0;
    fmt = 2'd0;
    nextWord = w;
    playHalf(1'b1, 32, lb);
    fmt = 2'd1;
    playHalf(1'b0, 32, rb);
    check(rb == expBits(0, w[31:16], 32, 32), "R10 format held mid frame", rb, expBits(0, w[31:16], 32, 32));
    w = 32'h2468_ACE1;
    playFrame(1, w, 32, lb, rb);
    check(lb == expBits(1, w[15:0], 32, 32), "R10 format taken at next rise", lb, expBits(1, w[15:0], 32, 32));
  endtask

  task automatic testUnderrun();
    logic [63:0] lb, rb;
    logic [31:0] w;
    check(underrun == 1'b0, "R9 flag clear before", {63'b0, underrun}, 64'h0);
    fifoEmpty = 1'b1;
    playFrame(0, 32'hFFFF_FFFF, 32, lb, rb);
    check(lb == 64'h0 && rb == 64'h0, "R9 zero word sent", lb | rb, 64'h0);
    check(underrun == 1'b1, "R9 flag set", {63'b0, underrun}, 64'h1);
    fifoEmpty = 1'b0;
    w = 32'h0F1E_2D3C;
    playFrame(0, w, 32, lb, rb);
    check(lb == expBits(0, w[15:0], 32, 32), "R9 data resumes", lb, expBits(0, w[15:0], 32, 32));
    check(underrun == 1'b1, "R9 flag sticky", {63'b0, underrun}, 64'h1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    testLeft();
    testDelay();
    testRight();
    testDsp();
    testModeChange();
    testUnderrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule